// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address for 4 KB pages. It makes two reads from memory. The first read fetches a directory entry, located from a base address held in a control register. The second read fetches a table entry, located from the table base that the directory entry gives. Access rights from both levels are combined and checked against the write and user flags of the request. The response carries either the translated address or a fault code.

A client offers one request at a time on a valid/ready port. The walker uses a simple memory read port. It raises a one-cycle read strobe with an address and waits as long as needed for a read-data strobe. When the paging-enable input is low at acceptance, the walker makes no memory access and returns the linear address unchanged.

Top module: `pgwalk_top`

## Requirements
- R1: If `paging_en` is 0 when a request is accepted, the response comes in the cycle right after the accepting edge. `rsp_paddr` equals `req_vaddr`, `rsp_fault` is 2'b00, and no memory read is made.
- R2: The first read of a walk uses address {`dir_base`[31:12], vaddr[31:22], 2'b00}. Both `dir_base` and the linear address are sampled when the request is accepted.
- R3: The second read uses address {directory entry[31:12], vaddr[21:12], 2'b00}.
- R4: A walk that succeeds returns `rsp_paddr` = {table entry[31:12], vaddr[11:0]} and `rsp_fault` = 2'b00.
- R5: A directory entry with bit 0 (present) equal to 0 ends the walk after one read. The response then has `rsp_fault` = 2'b01 and `rsp_paddr` = 0.
- R6: A table entry with bit 0 equal to 0 gives `rsp_fault` = 2'b01 and `rsp_paddr` = 0. This holds whatever the rights bits at either level are.
- R7: The effective writable right is the AND of bit 1 of both entries. The effective user right is the AND of bit 2 of both entries. A write without the writable right, or a user request without the user right, gives `rsp_fault` = 2'b10 and `rsp_paddr` = 0. Code 2'b11 never appears.
- R8: `req_ready` is 1 only when no walk is in progress. It falls on the accepting edge and returns one cycle after the response. Requests offered while it is 0 are ignored and produce no response.
- R9: After reset, `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0. `rsp_valid` and `mem_req_valid` are single-cycle pulses.
- R10: If memory answers one cycle after each read strobe, a full walk responds 4 cycles after the accepting edge. A directory-level not-present fault responds 2 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| paging_en | input | 1 | 1: translate; 0: pass the address through (sampled at acceptance) |
| dir_base | input | 32 | Control register holding the directory base; bits [31:12] are used |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| mem_req_valid | output | 1 | One-cycle read strobe |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 protection |

## Verification
The translation path is tried with several request types:
- A bypass request with paging disabled. This separates pass-through from a walk.
- User reads and writes that resolve through a fully permissive path. These check frame and offset composition, including the top page offset.
- Supervisor and user requests against a read-only supervisor page, and against a writable supervisor page. These show that each right is checked on its own axis.
- Requests through a directory entry that is read-only and supervisor-only, pointing to a permissive table entry. This separates an AND of the two levels from a check of the table level alone.

Missing entries are tried at each level, including an absent directory slot. The fault code, the number of reads and the latency tell these cases apart. A request held on the port during a walk shows that a busy walker drops it.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_NOTPRES = 2'b01,
    FLT_PROT    = 2'b10
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WT,
    ST_TBL_RD,
    ST_TBL_WT,
    ST_DONE
  } walk_st_e;

  // Entry flag positions shared by both levels
  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_WRITE   = 1;
  localparam int unsigned BIT_USER    = 2;

endpackage

// File: rtl/pgwalk_perm.sv
// Decodes one entry and folds its rights into the running AND of the walk.
module pgwalk_perm
  import pgwalk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic [ADDR_W-1:0]       entry,
  input  logic                    acc_w_in,
  input  logic                    acc_u_in,
  input  logic                    req_write,
  input  logic                    req_user,
  output logic                    present,
  output logic                    acc_w_out,
  output logic                    acc_u_out,
  output logic                    violation,
  output logic [ADDR_W-OFF_W-1:0] frame
);

  always_comb begin
    present   = entry[BIT_PRESENT];
    acc_w_out = acc_w_in & entry[BIT_WRITE];
    acc_u_out = acc_u_in & entry[BIT_USER];
    violation = (req_write & ~acc_w_out) | (req_user & ~acc_u_out);
    frame     = entry[ADDR_W-1:OFF_W];
  end

endmodule

// File: rtl/pgwalk_fsm.sv
// Walk sequencer: one outstanding walk, bypass straight to the response.
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire,
  input  logic     paging_en,
  input  logic     mem_rsp_valid,
  input  logic     present,
  output walk_st_e state
);

  walk_st_e state_n;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:   if (fire) state_n = paging_en ? ST_DIR_RD : ST_DONE;
      ST_DIR_RD: state_n = ST_DIR_WT;
      ST_DIR_WT: if (mem_rsp_valid) state_n = present ? ST_TBL_RD : ST_DONE;
      ST_TBL_RD: state_n = ST_TBL_WT;
      ST_TBL_WT: if (mem_rsp_valid) state_n = ST_DONE;
      ST_DONE:   state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              paging_en,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fault
);

  localparam int unsigned FRAME_W = ADDR_W - OFF_W;
  localparam int unsigned IDX_W   = FRAME_W / 2;
  localparam int unsigned ENT_LG  = OFF_W - IDX_W;

  walk_st_e state;
  logic fire;
  logic present, acc_w_new, acc_u_new, violation;
  logic acc_w_in, acc_u_in;
  logic [FRAME_W-1:0] ent_frame;

  logic [ADDR_W-1:0]  va_q, va_n;
  logic               wr_q, wr_n, us_q, us_n;
  logic [FRAME_W-1:0] base_q, base_n, tbase_q, tbase_n;
  logic               accw_q, accw_n, accu_q, accu_n;
  logic [ADDR_W-1:0]  pa_q, pa_n;
  fault_e             flt_q, flt_n;
  logic               cap_en, dir_en, tbl_en;

  assign fire = req_valid & req_ready;

  pgwalk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .paging_en     (paging_en),
    .mem_rsp_valid (mem_rsp_valid),
    .present       (present),
    .state         (state)
  );

  // Directory level starts from full rights; table level uses the held AND.
  assign acc_w_in = (state == ST_DIR_WT) ? 1'b1 : accw_q;
  assign acc_u_in = (state == ST_DIR_WT) ? 1'b1 : accu_q;

  pgwalk_perm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_perm (
    .entry     (mem_rsp_data),
    .acc_w_in  (acc_w_in),
    .acc_u_in  (acc_u_in),
    .req_write (wr_q),
    .req_user  (us_q),
    .present   (present),
    .acc_w_out (acc_w_new),
    .acc_u_out (acc_u_new),
    .violation (violation),
    .frame     (ent_frame)
  );

  assign cap_en = fire;
  assign dir_en = (state == ST_DIR_WT) & mem_rsp_valid;
  assign tbl_en = (state == ST_TBL_WT) & mem_rsp_valid;

  always_comb begin
    va_n    = va_q;
    wr_n    = wr_q;
    us_n    = us_q;
    base_n  = base_q;
    tbase_n = tbase_q;
    accw_n  = accw_q;
    accu_n  = accu_q;
    pa_n    = pa_q;
    flt_n   = flt_q;
    if (cap_en) begin
      va_n   = req_vaddr;
      wr_n   = req_write;
      us_n   = req_user;
      base_n = dir_base[ADDR_W-1:OFF_W];
      pa_n   = req_vaddr;
      flt_n  = FLT_NONE;
    end
    if (dir_en) begin
      if (!present) begin
        pa_n  = '0;
        flt_n = FLT_NOTPRES;
      end else begin
        tbase_n = ent_frame;
        accw_n  = acc_w_new;
        accu_n  = acc_u_new;
      end
    end
    if (tbl_en) begin
      if (!present) begin
        pa_n  = '0;
        flt_n = FLT_NOTPRES;
      end else if (violation) begin
        pa_n  = '0;
        flt_n = FLT_PROT;
      end else begin
        pa_n  = {ent_frame, va_q[OFF_W-1:0]};
        flt_n = FLT_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      wr_q    <= 1'b0;
      us_q    <= 1'b0;
      base_q  <= '0;
      tbase_q <= '0;
      accw_q  <= 1'b0;
      accu_q  <= 1'b0;
      pa_q    <= '0;
      flt_q   <= FLT_NONE;
    end else begin
      va_q    <= va_n;
      wr_q    <= wr_n;
      us_q    <= us_n;
      base_q  <= base_n;
      tbase_q <= tbase_n;
      accw_q  <= accw_n;
      accu_q  <= accu_n;
      pa_q    <= pa_n;
      flt_q   <= flt_n;
    end
  end

  always_comb begin
    req_ready     = (state == ST_IDLE);
    mem_req_valid = (state == ST_DIR_RD) | (state == ST_TBL_RD);
    if (state == ST_TBL_RD)
      mem_req_addr = {tbase_q, va_q[OFF_W+IDX_W-1 -: IDX_W], {ENT_LG{1'b0}}};
    else
      mem_req_addr = {base_q, va_q[ADDR_W-1 -: IDX_W], {ENT_LG{1'b0}}};
    rsp_valid = (state == ST_DONE);
    rsp_paddr = pa_q;
    rsp_fault = flt_q;
  end

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              paging_en,
  input logic [ADDR_W-1:0] dir_base,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [1:0]        rsp_fault
);

  localparam int unsigned IDX_W  = (ADDR_W - OFF_W) / 2;
  localparam int unsigned ENT_LG = OFF_W - IDX_W;

  logic [ADDR_W-1:0] hva, hbase;
  logic [1:0]        nreads;
  logic              acc;

  assign acc = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hva    <= '0;
      hbase  <= '0;
      nreads <= '0;
    end else begin
      if (acc) begin
        hva    <= req_vaddr;
        hbase  <= dir_base;
        nreads <= '0;
      end else if (mem_req_valid && nreads != 2'd3) begin
        nreads <= nreads + 2'd1;
      end
    end
  end

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  a_r8_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !paging_en) |=> (rsp_valid && rsp_paddr == $past(req_vaddr) && rsp_fault == 2'b00));

  a_r2_dir_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && nreads == 2'd0) |->
      mem_req_addr == {hbase[ADDR_W-1:OFF_W], hva[ADDR_W-1 -: IDX_W], {ENT_LG{1'b0}}});

  a_r3_tbl_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && nreads == 2'd1) |->
      mem_req_addr[OFF_W-1:0] == {hva[OFF_W+IDX_W-1 -: IDX_W], {ENT_LG{1'b0}}});

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b00) |-> rsp_paddr[OFF_W-1:0] == hva[OFF_W-1:0]);

  a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0);

  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11);

endmodule

bind pgwalk_top pgwalk_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/pgwalk_top_test.sv
`timescale 1ns/1ps
module pgwalk_top_test;

  logic        clk, rst_n;
  logic        paging_en;
  logic [31:0] dir_base;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_vaddr;
  logic        mem_req_valid, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_chk, n_bad;
  bit finished;

  pgwalk_top uut (
    .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Sparse memory, one-cycle read latency; absent words read as zero.
  logic [31:0] mem [logic [31:0]];
  int          n_reads;
  logic [31:0] prev_addr, last_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      n_reads       <= 0;
      prev_addr     <= '0;
      last_addr     <= '0;
    end else begin
      mem_rsp_valid <= mem_req_valid;
      if (mem_req_valid) begin
        mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
        n_reads      <= n_reads + 1;
        prev_addr    <= last_addr;
        last_addr    <= mem_req_addr;
      end
    end
  end

  typedef struct packed {
    logic        pg;
    logic [31:0] va;
    logic        wr;
    logic        us;
    logic [31:0] pa;
    logic [1:0]  flt;
    logic [3:0]  cyc;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'hDEADBEEF, 1'b1, 1'b1, 32'hDEADBEEF, 2'b00, 4'd0},
    '{1'b1, 32'h00405123, 1'b0, 1'b1, 32'hABCDE123, 2'b00, 4'd4},
    '{1'b1, 32'h00405FFF, 1'b1, 1'b1, 32'hABCDEFFF, 2'b00, 4'd4},
    '{1'b1, 32'h00406010, 1'b0, 1'b0, 32'h12345010, 2'b00, 4'd4},
    '{1'b1, 32'h00406010, 1'b1, 1'b0, 32'h00000000, 2'b10, 4'd4},
    '{1'b1, 32'h00406010, 1'b0, 1'b1, 32'h00000000, 2'b10, 4'd4},
    '{1'b1, 32'h00407000, 1'b0, 1'b0, 32'h00000000, 2'b01, 4'd4},
    '{1'b1, 32'h00C00000, 1'b0, 1'b0, 32'h00000000, 2'b01, 4'd2},
    '{1'b1, 32'h00000ABC, 1'b1, 1'b1, 32'h00000000, 2'b01, 4'd2},
    '{1'b1, 32'h00408ABC, 1'b1, 1'b0, 32'h55555ABC, 2'b00, 4'd4},
    '{1'b1, 32'h00408ABC, 1'b0, 1'b1, 32'h00000000, 2'b10, 4'd4},
    '{1'b1, 32'h00809044, 1'b0, 1'b0, 32'h77777044, 2'b00, 4'd4},
    '{1'b1, 32'h00809044, 1'b1, 1'b0, 32'h00000000, 2'b10, 4'd4},
    '{1'b1, 32'h00809044, 1'b0, 1'b1, 32'h00000000, 2'b10, 4'd4},
    '{1'b0, 32'h00000000, 1'b0, 1'b0, 32'h00000000, 2'b00, 4'd0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Offers one request at a negedge; returns result and edges after acceptance.
  task automatic run_req(input logic pg, input logic [31:0] va, input logic wr,
                         input logic us, output logic [31:0] pa,
                         output logic [1:0] flt, output int cyc,
                         output logic busy_ready, output int reads);
    int r0;
    r0 = n_reads;
    paging_en = pg;
    req_vaddr = va;
    req_write = wr;
    req_user  = us;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid  = 1'b0;
    busy_ready = req_ready;
    cyc = 0;
    while (!rsp_valid && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    pa    = rsp_paddr;
    flt   = rsp_fault;
    reads = n_reads - r0;
    @(negedge clk);
  endtask

  initial begin
    #(200_000 * 10);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa;
    logic [1:0]  flt;
    int          cyc, reads;
    logic        brdy;
    string       tag;

    n_chk = 0; n_bad = 0; finished = 0;
    rst_n = 1'b0;
    paging_en = 1'b0; dir_base = 32'h00100000;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;

    mem[32'h00100004] = 32'h00200007;
    mem[32'h00100008] = 32'h00300001;
    mem[32'h0010000C] = 32'h00400006;
    mem[32'h00200014] = 32'hABCDE007;
    mem[32'h00200018] = 32'h12345001;
    mem[32'h0020001C] = 32'h00000006;
    mem[32'h00200020] = 32'h55555003;
    mem[32'h00300024] = 32'h77777007;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check(req_ready == 1'b1, "R9 ready", {31'd0, req_ready}, 32'd1);
    check(mem_req_valid == 1'b0, "R9 memreq", {31'd0, mem_req_valid}, 32'd0);
    check(rsp_valid == 1'b0, "R9 rsp", {31'd0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_req(VECS[i].pg, VECS[i].va, VECS[i].wr, VECS[i].us, pa, flt, cyc, brdy, reads);
      if (!VECS[i].pg)            tag = "R1";
      else if (VECS[i].flt == 2'b01) tag = (VECS[i].cyc == 4'd2) ? "R5" : "R6";
      else if (VECS[i].flt == 2'b10) tag = "R7";
      else                         tag = "R4";
      check(pa == VECS[i].pa, tag, pa, VECS[i].pa);
      check(flt == VECS[i].flt, tag, {30'd0, flt}, {30'd0, VECS[i].flt});
      check(cyc == int'(VECS[i].cyc), "R10 latency", cyc, {28'd0, VECS[i].cyc});
      check(brdy == 1'b0, "R8 busy", {31'd0, brdy}, 32'd0);
      if (!VECS[i].pg)
        check(reads == 0, "R1 no reads", reads, 32'd0);
      if (VECS[i].cyc == 4'd2)
        check(reads == 1, "R5 one read", reads, 32'd1);
    end

    // R2 / R3 read addresses for a walk through directory slot 1, table slot 5
    run_req(1'b1, 32'h00405123, 1'b0, 1'b1, pa, flt, cyc, brdy, reads);
    check(reads == 2, "R3 two reads", reads, 32'd2);
    check(prev_addr == 32'h00100004, "R2 dir addr", prev_addr, 32'h00100004);
    check(last_addr == 32'h00200014, "R3 tbl addr", last_addr, 32'h00200014);

    // R2 base sampled at acceptance: change dir_base mid-walk
    paging_en = 1'b1; req_vaddr = 32'h00809044; req_write = 1'b0; req_user = 1'b0;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    dir_base  = 32'h00900000;
    while (!rsp_valid) @(negedge clk);
    check(rsp_paddr == 32'h77777044, "R2 base held", rsp_paddr, 32'h77777044);
    check(prev_addr == 32'h00100008, "R2 base held addr", prev_addr, 32'h00100008);
    @(negedge clk);
    dir_base = 32'h00100000;

    // R8 request offered while busy is dropped
    paging_en = 1'b1; req_vaddr = 32'h00405123; req_write = 1'b0; req_user = 1'b1;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_vaddr = 32'hCAFE0000; paging_en = 1'b0;
    check(req_ready == 1'b0, "R8 ready low", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    check(req_ready == 1'b0, "R8 ready low2", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check(rsp_paddr == 32'hABCDE123, "R8 first result", rsp_paddr, 32'hABCDE123);
    @(negedge clk);
    check(req_ready == 1'b1, "R8 ready back", {31'd0, req_ready}, 32'd1);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 8; k++) begin
        if (rsp_valid) extra++;
        @(negedge clk);
      end
      check(extra == 0, "R8 no extra rsp", extra, 32'd0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule